// File: doc/BRIEF.md
# Lane-partitioned fixed-point add/subtract ALU

This block is a 64-bit integer arithmetic unit that treats both of its operands as packed vectors. A two-bit lane code chosen with every operation splits the 64 bits into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Addition and subtraction then run independently in each lane, with no carry passing from one lane into the next.

Besides lane-wise add and subtract, the unit has a combined operation. It returns the sum and the difference of the same two operands on two separate 64-bit result paths. It also offers bitwise AND, OR and XOR at 32-bit or 64-bit width, a flag-setting copy, and a plain copy that leaves the flags alone. Results and flags are registered, so they appear one clock after an accepted request, together with a valid strobe. Flags hold their value until an operation that writes them.

Top module: `simd_alu`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. Results appear exactly one clock after a request with `in_valid` high.
- R2: Opcode 0 (add) gives, in every lane, (x + y) mod 2^w, where w is the lane width. Lane code 0 selects 8-bit lanes, 1 selects 16, 2 selects 32 and 3 selects 64. Lane i occupies bits [i*w+w-1 : i*w], and no carry crosses a lane boundary.
- R3: Opcode 1 (subtract) gives (x - y) mod 2^w in every lane, with the same lane layout as R2.
- R4: Opcode 2 (dual) puts the lane-wise sum of `src_x` and `src_y` on `res_a` and their lane-wise difference on `res_b`. For every other opcode, `res_b` is zero.
- R5: Opcodes 3, 4 and 5 are bitwise AND, OR and XOR. With lane code 3 they cover all 64 bits. With any other lane code they cover bits [31:0], and `res_a[63:32]` is zero.
- R6: Opcode 6 (pass) copies `src_x` to `res_a` and updates the flags: Z is set when the 64-bit value is zero, N is bit 63, and C and V are cleared.
- R7: Opcode 7 (move) copies `src_x` to `res_a` and leaves all four flags unchanged.
- R8: Arithmetic flags (opcodes 0 to 2, taken from the sum for opcode 2) are each ORed across lanes. Z means some lane result is zero. N means some lane's top bit is set. C means some lane produced a carry out; for subtract this is the carry out of x + ~y + 1, so no borrow gives C=1. V means some lane had signed overflow.
- R9: Logical opcodes set Z when the result over the used width (32 or 64 bits) is zero and set N from the top bit of that width. They clear C and V.
- R10: While `rst` is high at a clock edge, `out_valid`, both results and all flags become zero.
- R11: A clock with `in_valid` low leaves `res_a`, `res_b` and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Opcode |
| lane | input | 2 | Lane width code |
| src_x | input | 64 | First operand |
| src_y | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe |
| res_a | output | 64 | Primary result |
| res_b | output | 64 | Difference result of the dual operation |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The properties assume that `op` and `lane` carry defined values whenever `in_valid` is high. They also assume that the source operands of a request are stable at the sampling edge, because several properties compare a registered result with the operand value from one clock earlier. The stimulus changes inputs only on the falling edge and always drives every request field. It covers all eight opcodes and all four lane codes, with carry-out, signed-overflow and all-zero lane values at each width. It mixes in idle cycles so that the hold behaviour is exercised.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int DATA_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int HALF_W  = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_ADDSUB = 3'd2,
        OP_AND    = 3'd3,
        OP_OR     = 3'd4,
        OP_XOR    = 3'd5,
        OP_PASS   = 3'd6,
        OP_MOVE   = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LN_8  = 2'd0,
        LN_16 = 2'd1,
        LN_32 = 2'd2,
        LN_64 = 2'd3
    } lane_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    // Bytes per lane for a lane code.
    function automatic int lane_bytes(input lane_e ln);
        return 1 << int'(ln);
    endfunction

    function automatic logic [DATA_W-1:0] bitwise(
        input alu_op_e op, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
        case (op)
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_alu_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic [NB*BYTE_W-1:0] x,
    input  logic [NB*BYTE_W-1:0] y,
    input  logic                 sub,
    input  lane_e                lane,
    output logic [NB*BYTE_W-1:0] sum,
    output logic [NB-1:0]        byte_cout,
    output logic [NB-1:0]        byte_ovf
);
    logic [NB-1:0] cin;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic [BYTE_W-1:0] xb, yb;
        logic [BYTE_W:0]   s;
        assign xb = x[k*BYTE_W +: BYTE_W];
        assign yb = y[k*BYTE_W +: BYTE_W] ^ {BYTE_W{sub}};
        if (k == 0) begin : g_first
            assign cin[k] = sub;
        end else begin : g_rest
            // A lane start takes the operation's carry-in, others chain.
            assign cin[k] = ((k % lane_bytes(lane)) == 0) ? sub : byte_cout[k-1];
        end
        assign s = {1'b0, xb} + {1'b0, yb} + {{BYTE_W{1'b0}}, cin[k]};
        assign sum[k*BYTE_W +: BYTE_W] = s[BYTE_W-1:0];
        assign byte_cout[k] = s[BYTE_W];
        assign byte_ovf[k]  = (xb[BYTE_W-1] == yb[BYTE_W-1]) &&
                              (s[BYTE_W-1] != xb[BYTE_W-1]);
    end
endmodule

// File: rtl/simd_lane_flags.sv
module simd_lane_flags
    import simd_alu_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic [NB*BYTE_W-1:0] sum,
    input  logic [NB-1:0]        byte_cout,
    input  logic [NB-1:0]        byte_ovf,
    input  lane_e                lane,
    output alu_flags_t           flags
);
    logic nz_run;

    always_comb begin
        flags  = '0;
        nz_run = 1'b0;
        for (int k = 0; k < NB; k++) begin
            nz_run = nz_run | (|sum[k*BYTE_W +: BYTE_W]);
            if (((k + 1) % lane_bytes(lane)) == 0) begin
                flags.z = flags.z | ~nz_run;
                flags.n = flags.n | sum[k*BYTE_W + BYTE_W - 1];
                flags.c = flags.c | byte_cout[k];
                flags.v = flags.v | byte_ovf[k];
                nz_run  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  op,
    input  logic [1:0]  lane,
    input  logic [63:0] src_x,
    input  logic [63:0] src_y,
    output logic        out_valid,
    output logic [63:0] res_a,
    output logic [63:0] res_b,
    output logic        flag_z,
    output logic        flag_n,
    output logic        flag_c,
    output logic        flag_v
);
    alu_op_e opc;
    lane_e   ln;
    assign opc = alu_op_e'(op);
    assign ln  = lane_e'(lane);

    logic [DATA_W-1:0] add_sum, sub_sum;
    logic [NBYTES-1:0] add_co, add_ov, sub_co, sub_ov;
    alu_flags_t        add_fl, sub_fl;

    simd_lane_adder #(.NB(NBYTES)) u_add (
        .x(src_x), .y(src_y), .sub(1'b0), .lane(ln),
        .sum(add_sum), .byte_cout(add_co), .byte_ovf(add_ov));
    simd_lane_adder #(.NB(NBYTES)) u_sub (
        .x(src_x), .y(src_y), .sub(1'b1), .lane(ln),
        .sum(sub_sum), .byte_cout(sub_co), .byte_ovf(sub_ov));

    simd_lane_flags #(.NB(NBYTES)) u_add_fl (
        .sum(add_sum), .byte_cout(add_co), .byte_ovf(add_ov), .lane(ln), .flags(add_fl));
    simd_lane_flags #(.NB(NBYTES)) u_sub_fl (
        .sum(sub_sum), .byte_cout(sub_co), .byte_ovf(sub_ov), .lane(ln), .flags(sub_fl));

    logic [DATA_W-1:0] nxt_a, nxt_b, logic_full;
    alu_flags_t        nxt_fl, fl_q;
    logic              wide;

    always_comb begin
        wide       = (ln == LN_64);
        logic_full = bitwise(opc, src_x, src_y);
        nxt_a      = '0;
        nxt_b      = '0;
        nxt_fl     = '0;
        case (opc)
            OP_ADD: begin
                nxt_a  = add_sum;
                nxt_fl = add_fl;
            end
            OP_SUB: begin
                nxt_a  = sub_sum;
                nxt_fl = sub_fl;
            end
            OP_ADDSUB: begin
                nxt_a  = add_sum;
                nxt_b  = sub_sum;
                nxt_fl = add_fl;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_a    = wide ? logic_full : {{HALF_W{1'b0}}, logic_full[HALF_W-1:0]};
                nxt_fl.z = (nxt_a == '0);
                nxt_fl.n = wide ? nxt_a[DATA_W-1] : nxt_a[HALF_W-1];
            end
            OP_PASS: begin
                nxt_a    = src_x;
                nxt_fl.z = (src_x == '0);
                nxt_fl.n = src_x[DATA_W-1];
            end
            default: begin
                nxt_a  = src_x;
                nxt_fl = fl_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_a     <= '0;
            res_b     <= '0;
            fl_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_a <= nxt_a;
                res_b <= nxt_b;
                fl_q  <= nxt_fl;
            end
        end
    end

    assign flag_z = fl_q.z;
    assign flag_n = fl_q.n;
    assign flag_c = fl_q.c;
    assign flag_v = fl_q.v;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  op,
    input logic [1:0]  lane,
    input logic [63:0] src_x,
    input logic [63:0] src_y,
    input logic        out_valid,
    input logic [63:0] res_a,
    input logic [63:0] res_b,
    input logic        flag_z,
    input logic        flag_n,
    input logic        flag_c,
    input logic        flag_v
);
    logic [3:0] fl;
    assign fl = {flag_z, flag_n, flag_c, flag_v};

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && fl == 4'b0 && res_a == 64'd0 && res_b == 64'd0));
    // R4
    dual_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd2 && lane == 2'd3) |=> (res_a + res_b == ($past(src_x) << 1)));
    // R4
    single_b_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != 3'd2) |=> (res_b == 64'd0));
    // R5
    logic_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 3'd3 && op <= 3'd5 && lane != 2'd3) |=> (res_a[63:32] == 32'd0));
    // R6
    pass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd6) |=> (res_a == $past(src_x) && !flag_c && !flag_v));
    // R7
    move_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd7) |=> ($stable(fl) && res_a == $past(src_x)));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(fl) && $stable(res_a) && $stable(res_b)));
endmodule

bind simd_alu simd_alu_chk u_chk (.*);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [1:0]  lane;
    logic [63:0] src_x, src_y;
    logic        out_valid;
    logic [63:0] res_a, res_b;
    logic        flag_z, flag_n, flag_c, flag_v;

    int n_vec  = 0;
    int n_fail = 0;

    // Model state
    logic [63:0] m_a = '0, m_b = '0;
    logic [3:0]  m_fl = '0;
    logic        m_v = 1'b0;

    always #5 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane(lane),
        .src_x(src_x), .src_y(src_y), .out_valid(out_valid),
        .res_a(res_a), .res_b(res_b),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v));

    task automatic lanewise(input logic [63:0] x, input logic [63:0] y, input logic [1:0] ln,
                            input bit sub, output logic [63:0] r, output logic [3:0] f);
        int w, nl;
        logic [64:0] mask, a, b, s, lr;
        w  = 8 << ln;
        nl = 64 / w;
        mask = (65'd1 << w) - 65'd1;
        r = '0;
        f = '0;
        for (int l = 0; l < nl; l++) begin
            a = ({1'b0, x} >> (l * w)) & mask;
            b = ({1'b0, y} >> (l * w)) & mask;
            if (sub) b = (~b) & mask;
            s  = a + b + (sub ? 65'd1 : 65'd0);
            lr = s & mask;
            r  = r | 64'(lr << (l * w));
            if (lr == 65'd0) f[3] = 1'b1;
            if (lr[w-1]) f[2] = 1'b1;
            if (s[w]) f[1] = 1'b1;
            if (a[w-1] == b[w-1] && lr[w-1] != a[w-1]) f[0] = 1'b1;
        end
    endtask

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4, 3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_step();
        logic [63:0] r, r2, lg;
        logic [3:0]  f, f2;
        if (rst) begin
            m_v = 0; m_a = '0; m_b = '0; m_fl = '0;
            return;
        end
        m_v = in_valid;
        if (!in_valid) return;      // R11: hold
        m_b = '0;
        case (op)
            3'd0: begin lanewise(src_x, src_y, lane, 0, r, f); m_a = r; m_fl = f; end
            3'd1: begin lanewise(src_x, src_y, lane, 1, r, f); m_a = r; m_fl = f; end
            3'd2: begin
                lanewise(src_x, src_y, lane, 0, r, f);
                lanewise(src_x, src_y, lane, 1, r2, f2);
                m_a = r; m_b = r2; m_fl = f;
            end
            3'd3, 3'd4, 3'd5: begin
                lg = (op == 3'd3) ? (src_x & src_y) : (op == 3'd4) ? (src_x | src_y) : (src_x ^ src_y);
                if (lane != 2'd3) lg[63:32] = '0;
                m_a = lg;
                m_fl = {lg == 64'd0, (lane == 2'd3) ? lg[63] : lg[31], 2'b00};
            end
            3'd6: begin m_a = src_x; m_fl = {src_x == 64'd0, src_x[63], 2'b00}; end
            default: m_a = src_x;
        endcase
    endtask

    task automatic compare(input string tg, input string ftg);
        n_vec++;
        if (out_valid !== m_v) begin
            n_fail++;
            $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, m_v);
        end
        if (res_a !== m_a || res_b !== m_b) begin
            n_fail++;
            $display("FAIL %s res act=%h/%h exp=%h/%h", tg, res_a, res_b, m_a, m_b);
        end
        if ({flag_z, flag_n, flag_c, flag_v} !== m_fl) begin
            n_fail++;
            $display("FAIL %s flags act=%b exp=%b", ftg,
                     {flag_z, flag_n, flag_c, flag_v}, m_fl);
        end
    endtask

    // Inputs are set at a falling edge; outputs checked at the next one.
    task automatic apply(input logic v, input logic [2:0] o, input logic [1:0] ln,
                         input logic [63:0] x, input logic [63:0] y);
        string tg, ftg;
        in_valid = v; op = o; lane = ln; src_x = x; src_y = y;
        tg  = rst ? "R10" : (v ? tag_of(o) : "R11");
        ftg = rst ? "R10" : !v ? "R11" : (o <= 3'd2) ? "R8" :
              (o <= 3'd5) ? "R9" : tag_of(o);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tg, ftg);
    endtask

    bit done = 0;

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; op = 0; lane = 0; src_x = '0; src_y = '0;
        @(negedge clk);
        apply(0, 0, 0, 0, 0);           // R10 reset state
        apply(1, 3'd0, 2'd3, 64'h1, 64'h1);  // request during reset ignored (R10)
        rst = 0;
        // R2: byte carries stay inside lanes
        apply(1, 3'd0, 2'd0, 64'h01FF_7F80_00FF_7FFF, 64'h0101_0180_0001_0101);
        apply(1, 3'd0, 2'd1, 64'hFFFF_7FFF_0001_8000, 64'h0001_0001_FFFF_8000);
        apply(1, 3'd0, 2'd2, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001);
        apply(1, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        apply(1, 3'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        // R3: subtraction, borrow and zero lanes
        apply(1, 3'd1, 2'd0, 64'h0000_8000_1234_5678, 64'h0100_0100_1234_5679);
        apply(1, 3'd1, 2'd1, 64'h8000_0005_0000_1111, 64'h0001_0005_0001_1111);
        apply(1, 3'd1, 2'd3, 64'h5, 64'h5);
        // R4: dual sum/difference
        apply(1, 3'd2, 2'd0, 64'h80FF_0102_0304_0506, 64'h8001_0102_FFFF_0102);
        apply(1, 3'd2, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        // R11 idle hold
        apply(0, 3'd0, 2'd0, 64'hFFFF, 64'hFFFF);
        // R5/R9 logical
        apply(1, 3'd3, 2'd3, 64'hF0F0_0000_FFFF_0000, 64'hFF00_0000_0F0F_0000);
        apply(1, 3'd4, 2'd1, 64'hFFFF_FFFF_8000_0000, 64'h0);
        apply(1, 3'd5, 2'd0, 64'hAAAA_AAAA_1234_5678, 64'h5555_5555_1234_5678);
        apply(1, 3'd5, 2'd3, 64'h8000_0000_0000_0000, 64'h0);
        // R7 then R6
        apply(1, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);   // sets Z,C
        apply(1, 3'd7, 2'd0, 64'hDEAD_BEEF_0000_0001, 64'h0);   // keeps flags
        apply(1, 3'd6, 2'd0, 64'h0, 64'h0);
        apply(1, 3'd6, 2'd2, 64'h8000_0000_0000_0001, 64'h0);
        apply(1, 3'd7, 2'd1, 64'h0, 64'h0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [63:0] rx, ry;
            rx = {$urandom, $urandom};
            ry = {$urandom, $urandom};
            if ((i % 7) == 0) ry = rx;
            apply(($urandom % 5) != 0, 3'($urandom), 2'($urandom), rx, ry);
        end
        // mid-run reset R10
        rst = 1;
        apply(1, 3'd0, 2'd0, 64'h1, 64'h1);
        rst = 0;
        apply(0, 3'd0, 2'd0, 64'h0, 64'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule